// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the control state of one channel of an IDE-style bus-master DMA controller. It has three registers: an 8-bit command register, an 8-bit status register and a 32-bit base pointer to the descriptor table. A host reaches them through a byte-addressed register port that takes 1-, 2- and 4-byte accesses. Writes to the command register produce one-cycle start and cancel pulses and a transfer-direction level for a separate descriptor-walking engine. On a start the block also hands that engine a current descriptor pointer, loaded from the base register.

The status register shows whether a transfer is active and latches error and interrupt events. Error and interrupt are cleared by writing a one to their bit, and two spare bits hold whatever software writes to them. The drive interrupt line passes straight through to the host interrupt output, and each rising edge of it is also recorded in status. The engine can end a transfer with a completion strobe and can report a fault. Register map: command at offset 0 and status at offset 2, both byte-wide. The base pointer fills offsets 4 to 7 in little-endian lane order. Read data appears on the cycle after the read request.

Top module: `bmdma_regs`

## Requirements
- R1: A byte write at offset 0 stores only bit 0 (go) and bit 3 (direction). A command read returns go in bit 0 and direction in bit 3, and every other bit reads 0. `eng_dir` shows the stored direction bit.
- R2: A command write whose bit 0 equals the stored go bit produces neither a start pulse nor a cancel pulse.
- R3: A command write that changes go from 1 to 0 clears the status active bit (bit 0). It also raises `eng_cancel` for exactly the one cycle after the write.
- R4: A command write that changes go from 0 to 1 loads `cur_ptr` from the base register. If the active bit was clear, it also sets active and raises `eng_start` for exactly the one cycle after the write. Start and cancel are never high together.
- R5: A byte write at offset 2 copies written bits 6:5 into status bits 6:5 and leaves the active bit unchanged. Status bits 7, 4 and 3 read 0.
- R6: Status bit 1 (error) and bit 2 (interrupt) are cleared only where the status write carries a 1. An `eng_fault` sets error, and it wins over a clear in the same cycle.
- R7: A rising edge on `drv_irq` sets the interrupt status bit, and a set wins over a clear in the same cycle. `host_irq` always equals `drv_irq`.
- R8: A write at offset 4+k with size s (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) updates only base byte lanes k up to k+bytes-1, capped at lane 3. Lane j takes write-data byte j-k, and base bits 1:0 always stay 0.
- R9: A read at offset 4+k with size s returns the base register shifted right by 8*k bits and masked to the access width, on the cycle after the request.
- R10: An `eng_done` strobe clears the active bit with no register write. A command write in the same cycle takes precedence.
- R11: Synchronous reset clears command, status, base and `cur_ptr`. If a transfer was active, `eng_cancel` is high in the cycle after the reset edge.
- R12: Any access to offsets 0 to 3 other than a byte access at offset 0 or offset 2 has no effect on a write and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Byte offset of the access |
| sz | input | 2 | Access size code: 0 byte, 1 halfword, 2/3 word |
| wdata | input | 32 | Write data, low byte is the addressed lane |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |
| eng_done | input | 1 | Engine completion strobe, clears active |
| eng_fault | input | 1 | Engine fault strobe, sets error |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_cancel | output | 1 | One-cycle cancel pulse to the engine |
| eng_dir | output | 1 | Transfer direction bit |
| cur_ptr | output | 32 | Current descriptor pointer for the engine |

## Verification
Register writes and event inputs take effect at the clock edge where they are sampled. The start and cancel pulses and the new `cur_ptr` can be seen in the cycle that follows that edge, and a read issued in that next cycle shows the new register contents. Read data is registered and lags its request by exactly one edge. `host_irq` is combinational and can be checked in the same cycle as `drv_irq`. The bench drives each stimulus on a falling edge and samples one time unit after the next rising edge. It runs every access as a separate one-cycle transaction, so each expected value is compared in the single cycle where it is due.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int REG_W    = 32;
    localparam int LANES    = REG_W / 8;
    localparam int OFS_W    = $clog2(LANES);
    localparam int ADDR_W   = OFS_W + 1;

    localparam logic [ADDR_W-1:0] CMD_OFS  = 3'd0;
    localparam logic [ADDR_W-1:0] STAT_OFS = 3'd2;

    localparam int CMD_GO   = 0;
    localparam int CMD_DIR  = 3;
    localparam int ST_ACT   = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_IRQ   = 2;
    localparam int ST_SPARE = 5;
    localparam int ALIGN_W  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_sz_e;

    typedef struct packed {
        logic              cmd_wr;
        logic              cmd_rd;
        logic              stat_wr;
        logic              stat_rd;
        logic              base_wr;
        logic              base_rd;
        logic [LANES-1:0]  lanes;
        logic [OFS_W-1:0]  off;
    } acc_t;

    function automatic int unsigned bytes_of(xfer_sz_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] width_mask(xfer_sz_e s);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++)
            if (i < int'(bytes_of(s))) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [LANES-1:0] lane_sel(logic [OFS_W-1:0] off, xfer_sz_e s);
        logic [LANES-1:0] l;
        l = '0;
        for (int i = 0; i < LANES; i++)
            if (i >= int'(off) && i < int'(off) + int'(bytes_of(s))) l[i] = 1'b1;
        return l;
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  xfer_sz_e          sz,
    output acc_t              acc
);
    logic in_base;
    logic byte_acc;

    always_comb begin
        in_base      = addr[ADDR_W-1];
        byte_acc     = (sz == SZ_BYTE);
        acc          = '0;
        acc.off      = addr[OFS_W-1:0];
        acc.lanes    = lane_sel(addr[OFS_W-1:0], sz);
        acc.cmd_wr   = req &  we & byte_acc & (addr == CMD_OFS);
        acc.cmd_rd   = req & ~we & byte_acc & (addr == CMD_OFS);
        acc.stat_wr  = req &  we & byte_acc & (addr == STAT_OFS);
        acc.stat_rd  = req & ~we & byte_acc & (addr == STAT_OFS);
        acc.base_wr  = req &  we & in_base;
        acc.base_rd  = req & ~we & in_base;
    end
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_t       acc,
    input  logic [7:0] wbyte,
    input  logic       drv_irq,
    input  logic       eng_done,
    input  logic       eng_fault,
    output logic [7:0] cmd_view,
    output logic [7:0] stat_view,
    output logic       go_rise,
    output logic       eng_start,
    output logic       eng_cancel,
    output logic       eng_dir
);
    logic       go_q, dir_q, act_q, err_q, irq_q, irq_prev;
    logic [1:0] spare_q;
    logic       start_q, cancel_q;
    logic       go_new, go_chg, irq_edge;

    assign go_new   = wbyte[CMD_GO];
    assign go_chg   = acc.cmd_wr & (go_new != go_q);
    assign go_rise  = go_chg & go_new;
    assign irq_edge = drv_irq & ~irq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cancel_q <= act_q;
            start_q  <= 1'b0;
            go_q     <= 1'b0;
            dir_q    <= 1'b0;
            act_q    <= 1'b0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
            spare_q  <= 2'b00;
            irq_prev <= 1'b0;
        end else begin
            start_q  <= 1'b0;
            cancel_q <= 1'b0;
            irq_prev <= drv_irq;
            if (eng_done) act_q <= 1'b0;
            if (acc.cmd_wr) begin
                go_q  <= go_new;
                dir_q <= wbyte[CMD_DIR];
                if (go_chg) begin
                    if (!go_new) begin
                        act_q    <= 1'b0;
                        cancel_q <= 1'b1;
                    end else if (!act_q) begin
                        act_q   <= 1'b1;
                        start_q <= 1'b1;
                    end
                end
            end
            if (acc.stat_wr) begin
                spare_q <= wbyte[ST_SPARE +: 2];
                if (wbyte[ST_ERR]) err_q <= 1'b0;
                if (wbyte[ST_IRQ]) irq_q <= 1'b0;
            end
            if (eng_fault) err_q <= 1'b1;
            if (irq_edge)  irq_q <= 1'b1;
        end
    end

    always_comb begin
        cmd_view           = '0;
        cmd_view[CMD_GO]   = go_q;
        cmd_view[CMD_DIR]  = dir_q;
        stat_view          = '0;
        stat_view[ST_ACT]  = act_q;
        stat_view[ST_ERR]  = err_q;
        stat_view[ST_IRQ]  = irq_q;
        stat_view[ST_SPARE +: 2] = spare_q;
    end

    assign eng_start  = start_q;
    assign eng_cancel = cancel_q;
    assign eng_dir    = dir_q;
endmodule

// File: rtl/bmdma_addr.sv
module bmdma_addr
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  xfer_sz_e         sz,
    input  logic [REG_W-1:0] wdata,
    input  logic             go_rise,
    output logic [REG_W-1:0] rd_base,
    output logic [REG_W-1:0] cur_ptr
);
    logic [REG_W-1:0] base_q;
    logic [REG_W-1:0] wshift;

    assign wshift = wdata << (8 * acc.off);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_low
            always_ff @(posedge clk) begin
                if (rst)
                    base_q[7:0] <= '0;
                else if (acc.base_wr && acc.lanes[0])
                    base_q[7:0] <= {wshift[7:ALIGN_W], {ALIGN_W{1'b0}}};
            end
        end else begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)
                    base_q[i*8 +: 8] <= '0;
                else if (acc.base_wr && acc.lanes[i])
                    base_q[i*8 +: 8] <= wshift[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          cur_ptr <= '0;
        else if (go_rise) cur_ptr <= base_q;
    end

    assign rd_base = (base_q >> (8 * acc.off)) & width_mask(sz);
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        we,
    input  logic [2:0]  addr,
    input  logic [1:0]  sz,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        drv_irq,
    output logic        host_irq,
    input  logic        eng_done,
    input  logic        eng_fault,
    output logic        eng_start,
    output logic        eng_cancel,
    output logic        eng_dir,
    output logic [31:0] cur_ptr
);
    acc_t             acc;
    xfer_sz_e         sz_e;
    logic [7:0]       cmd_view, stat_view;
    logic [REG_W-1:0] rd_base;
    logic             go_rise;

    assign sz_e = xfer_sz_e'(sz);

    bmdma_decode u_dec (
        .req(req), .we(we), .addr(addr), .sz(sz_e), .acc(acc)
    );

    bmdma_ctrl u_ctrl (
        .clk(clk), .rst(rst), .acc(acc), .wbyte(wdata[7:0]),
        .drv_irq(drv_irq), .eng_done(eng_done), .eng_fault(eng_fault),
        .cmd_view(cmd_view), .stat_view(stat_view), .go_rise(go_rise),
        .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_dir(eng_dir)
    );

    bmdma_addr u_addr (
        .clk(clk), .rst(rst), .acc(acc), .sz(sz_e), .wdata(wdata),
        .go_rise(go_rise), .rd_base(rd_base), .cur_ptr(cur_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req && !we) begin
            if (acc.base_rd)      rdata <= rd_base;
            else if (acc.cmd_rd)  rdata <= {24'd0, cmd_view};
            else if (acc.stat_rd) rdata <= {24'd0, stat_view};
            else                  rdata <= '0;
        end
    end

    assign host_irq = drv_irq;
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        we,
    input logic [2:0]  addr,
    input logic [1:0]  sz,
    input logic [31:0] rdata,
    input logic        drv_irq,
    input logic        host_irq,
    input logic        eng_start,
    input logic        eng_cancel
);
    p_cmd_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr == 3'd0 && sz == 2'd0) |=> (rdata[31:4] == '0 && rdata[2:1] == 2'b00));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(eng_start && eng_cancel));

    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    p_cancel_single_r3: assert property (@(posedge clk) disable iff (rst)
        eng_cancel |=> !eng_cancel);

    p_stat_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr == 3'd2 && sz == 2'd0) |=> (rdata[31:7] == '0 && rdata[4:3] == 2'b00));

    p_base_align_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr == 3'd4) |=> (rdata[1:0] == 2'b00));

    p_gap_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr[2] == 1'b0 && (addr[0] == 1'b1 || sz != 2'd0)) |=> (rdata == '0));

    always_comb begin
        a_irq_pass_r7: assert (host_irq == drv_irq);
    end
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .sz(sz),
    .rdata(rdata), .drv_irq(drv_irq), .host_irq(host_irq),
    .eng_start(eng_start), .eng_cancel(eng_cancel)
);

// File: tb/sim_bmdma_regs.sv
module sim_bmdma_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [1:0]  sz = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        drv_irq = 1'b0, host_irq;
    logic        eng_done = 1'b0, eng_fault = 1'b0;
    logic        eng_start, eng_cancel, eng_dir;
    logic [31:0] cur_ptr;

    int n_vec = 0;
    int n_bad = 0;

    logic        m_go, m_dir, m_act, m_err, m_irq;
    logic [1:0]  m_sp;
    logic [31:0] m_base, m_cur;
    logic        e_start, e_cancel;

    always #5 clk = ~clk;

    bmdma_regs u0 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .sz(sz),
        .wdata(wdata), .rdata(rdata), .drv_irq(drv_irq), .host_irq(host_irq),
        .eng_done(eng_done), .eng_fault(eng_fault), .eng_start(eng_start),
        .eng_cancel(eng_cancel), .eng_dir(eng_dir), .cur_ptr(cur_ptr)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", r, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a, input logic [1:0] s);
        logic [31:0] v;
        v = '0;
        if (a[2]) begin
            v = m_base >> (8 * a[1:0]);
            for (int i = 0; i < 4; i++) if (i >= nbytes(s)) v[i*8 +: 8] = 8'h00;
        end else if (s == 2'd0 && a == 3'd0) begin
            v[0] = m_go; v[3] = m_dir;
        end else if (s == 2'd0 && a == 3'd2) begin
            v[0] = m_act; v[1] = m_err; v[2] = m_irq; v[6:5] = m_sp;
        end
        return v;
    endfunction

    // one write transaction; optional fault strobe in the same cycle
    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d,
                      input logic flt, input string r);
        int k;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; sz = s; wdata = d; eng_fault = flt;
        e_start = 1'b0; e_cancel = 1'b0;
        if (a == 3'd0 && s == 2'd0) begin
            if (d[0] != m_go) begin
                if (!d[0]) begin e_cancel = 1'b1; m_act = 1'b0; end
                else begin
                    m_cur = m_base;
                    if (!m_act) begin m_act = 1'b1; e_start = 1'b1; end
                end
            end
            m_go = d[0]; m_dir = d[3];
        end else if (a == 3'd2 && s == 2'd0) begin
            m_sp = d[6:5];
            if (d[1]) m_err = 1'b0;
            if (d[2]) m_irq = 1'b0;
        end else if (a[2]) begin
            k = a[1:0];
            for (int j = 0; j < 4; j++)
                if (j >= k && j < k + nbytes(s)) m_base[j*8 +: 8] = d[(j-k)*8 +: 8];
            m_base[1:0] = 2'b00;
        end
        if (flt) m_err = 1'b1;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0; eng_fault = 1'b0;
        chk({r, " start"}, {31'd0, eng_start}, {31'd0, e_start});
        chk({r, " cancel"}, {31'd0, eng_cancel}, {31'd0, e_cancel});
        chk({r, " dir"}, {31'd0, eng_dir}, {31'd0, m_dir});
        chk({r, " cur_ptr"}, cur_ptr, m_cur);
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, input string r);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; sz = s;
        @(posedge clk); #1;
        req = 1'b0;
        chk(r, rdata, exp_read(a, s));
    endtask

    task automatic irq_rise();
        @(negedge clk); drv_irq = 1'b0;
        @(posedge clk); #1;
        chk("R7 host_irq low", {31'd0, host_irq}, 32'd0);
        @(negedge clk); drv_irq = 1'b1; m_irq = 1'b1;
        @(posedge clk); #1;
        chk("R7 host_irq high", {31'd0, host_irq}, 32'd1);
    endtask

    task automatic model_reset();
        m_go = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0; m_sp = 0;
        m_base = 0; m_cur = 0;
    endtask

    initial begin
        #1500000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R11 no cancel idle reset", {31'd0, eng_cancel}, 32'd0);
        @(negedge clk); rst = 1'b0;
        rd(3'd0, 2'd0, "R11 cmd after reset");
        rd(3'd2, 2'd0, "R11 status after reset");
        rd(3'd4, 2'd2, "R11 base after reset");

        // R8/R9: every offset and size written, every offset and size read back
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 4; s++) begin
                wr(3'(4 + o), 2'(s), 32'h9E3779B9 * (o * 4 + s + 1), 1'b0, "R8 base write");
                for (int ro = 0; ro < 4; ro++)
                    for (int rs = 0; rs < 4; rs++)
                        rd(3'(4 + ro), 2'(rs), "R9 base read");
            end

        // R1..R4: all 256 command bytes, base changing along the way
        for (int v = 0; v < 256; v++) begin
            if (v % 8 == 0) wr(3'd4, 2'd2, {8'(v), 8'(v ^ 8'h5A), 8'(~v), 8'(v + 3)}, 1'b0, "R8 base word");
            wr(3'd0, 2'd0, 32'(v), 1'b0, "R2 R3 R4 cmd write");
            rd(3'd0, 2'd0, "R1 cmd read");
            rd(3'd2, 2'd0, "R3 R4 active");
        end
        // repeat same go value: no pulses (R2)
        wr(3'd0, 2'd0, 32'h01, 1'b0, "R4 go set");
        wr(3'd0, 2'd0, 32'h09, 1'b0, "R2 same go");
        wr(3'd0, 2'd0, 32'hF7, 1'b0, "R2 same go other bits");
        rd(3'd0, 2'd0, "R1 after same go");

        // R5/R6/R7: status sweep with error and interrupt pending each time
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 2'd0, 32'(v & 1), 1'b0, "R5 go toggle");
            irq_rise();
            wr(3'd1, 2'd0, 32'h0, 1'b1, "R6 fault strobe");
            wr(3'd2, 2'd0, 32'(v), 1'b0, "R5 R6 status write");
            rd(3'd2, 2'd0, "R5 R6 status read");
        end

        // R6: fault wins over clear in the same cycle
        wr(3'd2, 2'd0, 32'h02, 1'b1, "R6 fault vs clear");
        rd(3'd2, 2'd0, "R6 error kept");
        // R7: rise wins over clear in the same cycle
        @(negedge clk); drv_irq = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); drv_irq = 1'b1;
        req = 1'b1; we = 1'b1; addr = 3'd2; sz = 2'd0; wdata = 32'h04; m_irq = 1'b1;
        @(posedge clk); #1; req = 1'b0; we = 1'b0;
        rd(3'd2, 2'd0, "R7 rise vs clear");
        // level held high: no new set after clear
        wr(3'd2, 2'd0, 32'h04, 1'b0, "R7 clear with level high");
        rd(3'd2, 2'd0, "R7 no re-set on level");
        @(negedge clk); drv_irq = 1'b0;

        // R10: completion clears active
        wr(3'd0, 2'd0, 32'h00, 1'b0, "R10 prep stop");
        wr(3'd0, 2'd0, 32'h01, 1'b0, "R10 start");
        @(negedge clk); eng_done = 1'b1; m_act = 1'b0;
        @(posedge clk); #1; eng_done = 1'b0;
        rd(3'd2, 2'd0, "R10 active cleared by done");
        rd(3'd0, 2'd0, "R10 go kept");
        wr(3'd0, 2'd0, 32'h00, 1'b0, "R3 stop after done");
        // done and start together: start wins
        @(negedge clk);
        eng_done = 1'b1; req = 1'b1; we = 1'b1; addr = 3'd0; sz = 2'd0; wdata = 32'h01;
        m_go = 1'b1; m_act = 1'b1; m_cur = m_base;
        @(posedge clk); #1; eng_done = 1'b0; req = 1'b0; we = 1'b0;
        chk("R10 start over done", {31'd0, eng_start}, 32'd1);
        rd(3'd2, 2'd0, "R10 active after tie");

        // R12: ignored accesses in the low window
        wr(3'd0, 2'd2, 32'hFFFF_FFF6, 1'b0, "R12 wide cmd write");
        wr(3'd2, 2'd1, 32'hFFFF_FFFF, 1'b0, "R12 wide status write");
        wr(3'd3, 2'd0, 32'hFF, 1'b0, "R12 gap write");
        rd(3'd0, 2'd0, "R12 cmd unchanged");
        rd(3'd2, 2'd0, "R12 status unchanged");
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 4; s++)
                rd(3'(a), 2'(s), "R12 low window read");

        // R11: reset while active issues cancel and clears all
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R11 reset cancel", {31'd0, eng_cancel}, 32'd1);
        model_reset();
        chk("R11 cur_ptr cleared", cur_ptr, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R11 cancel one cycle", {31'd0, eng_cancel}, 32'd0);
        rd(3'd0, 2'd0, "R11 cmd cleared");
        rd(3'd2, 2'd0, "R11 status cleared");
        rd(3'd4, 2'd2, "R11 base cleared");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule